// File: doc/BRIEF.md
# Memory Bank Configuration Register Block

This block is the byte-wide port register file of a memory controller with six module sockets. Firmware finds out what is fitted by reading two read-only bytes that are derived from static size straps: a large-module byte and a presence byte. It then programs an eight-entry table of bank end addresses, which the address decoder next door uses. The end addresses count in 8 MB units.

The table is written through one port, and each write byte carries its own entry number. Reads go through the same port but follow an internal pointer. Each read steps the pointer by one, and the pointer wraps after the eighth entry. Reading the presence byte sets the pointer back to entry 0, so software can start a read-back sweep from a known place. A parity-status port always reports that no error has been seen.

Read data is registered. It appears on the clock edge that samples the read strobe and holds until the next read. Each clock cycle with the read strobe high counts as one access.

Top module: `memcfg_regs`

## Requirements
- R1: While reset is asserted and right after it is released, `rdata_o` is 0x00, every table entry on `end_addr_o` is 0, and the read pointer is at entry 0.
- R2: A read of address 0x03 returns a byte in which bit n (n = 0..5) is 1 exactly when socket n's strap code is 2'b10 or 2'b11 (32 MB). Bits 7:6 are 0.
- R3: A read of address 0x04 returns 0xFF with bit n (n = 0..5) cleared when socket n's strap code is not 2'b00. Bits 7:6 always read 1.
- R4: A write to address 0x20 stores data bits [4:0] into the entry selected by data bits [7:5]. Entry k appears on `end_addr_o[5k+4:5k]` from the edge that samples the write.
- R5: A read of address 0x20 returns the entry at the read pointer in bits [4:0], with bits [7:5] zero. The pointer then advances by one and wraps from 7 to 0.
- R6: A read of address 0x04 returns the pointer to entry 0, whatever its previous value.
- R7: A read of address 0x41 always returns 0x01.
- R8: Reads of any other address return 0xFF. Writes to any address other than 0x20 change neither the table nor the read pointer.
- R9: When the read and write strobes are both high in one cycle at address 0x20, the read returns the entry's value from before the write. The write is stored and the pointer advances.
- R10: `rdata_o` changes only on an edge that samples the read strobe high. It holds its value through cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Port address |
| rd_i | input | 1 | Read strobe, one access per high cycle |
| wr_i | input | 1 | Write strobe, one access per high cycle |
| wdata_i | input | 8 | Write data: [7:5] entry number, [4:0] end address |
| strap_i | input | 12 | Size strap per socket, 2 bits each: 00 empty, 01 8 MB, 1x 32 MB |
| rdata_o | output | 8 | Registered read data |
| end_addr_o | output | 40 | Eight 5-bit end-address entries, entry k at [5k+4:5k] |

## Verification
The table's read path and write path can act in the same cycle, because one bus cycle may carry both strobes at address 0x20. The bench first moves the read pointer onto an entry. It then issues a combined read and write to that same entry. The returned byte must be the old value, `end_addr_o` must show the new value from the next cycle on, and a later sweep that starts from the presence-read reset must return the new value and confirm that the pointer advanced once.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 8;
  localparam logic [AW-1:0] ADDR_ID   = 8'h03;
  localparam logic [AW-1:0] ADDR_PRES = 8'h04;
  localparam logic [AW-1:0] ADDR_END  = 8'h20;
  localparam logic [AW-1:0] ADDR_PAR  = 8'h41;
  localparam logic [DW-1:0] PAR_OK    = 8'h01;
  localparam logic [DW-1:0] RD_UNMAP  = 8'hFF;
endpackage

// File: rtl/memcfg_strap_decode.sv
module memcfg_strap_decode #(
  parameter int unsigned NSOCK = 6,
  parameter int unsigned DW    = 8
) (
  input  logic [2*NSOCK-1:0] strap_i,
  output logic [DW-1:0]      id_o,
  output logic [DW-1:0]      pres_o
);
  for (genvar s = 0; s < DW; s++) begin : g_bit
    if (s < NSOCK) begin : g_sock
      assign id_o[s]   = strap_i[2*s+1];
      assign pres_o[s] = ~|strap_i[2*s +: 2];
    end else begin : g_pad
      assign id_o[s]   = 1'b0;
      assign pres_o[s] = 1'b1;
    end
  end
endmodule

// File: rtl/memcfg_end_table.sv
module memcfg_end_table #(
  parameter int unsigned NENT = 8,
  parameter int unsigned EW   = 5,
  localparam int unsigned IW  = $clog2(NENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [EW-1:0]    wr_val_i,
  input  logic             rd_en_i,
  input  logic             clr_idx_i,
  output logic [EW-1:0]    rd_val_o,
  output logic [IW-1:0]    rd_idx_o,
  output logic [NENT*EW-1:0] end_addr_o
);
  logic [EW-1:0] ent_q [NENT];
  logic [IW-1:0] idx_q;

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              ent_q[e] <= '0;
      else if (wr_en_i && wr_idx_i == IW'(e))   ent_q[e] <= wr_val_i;
    end
    assign end_addr_o[e*EW +: EW] = ent_q[e];
  end

  // presence read wins over a pointer step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        idx_q <= '0;
    else if (clr_idx_i) idx_q <= '0;
    else if (rd_en_i)   idx_q <= (idx_q == IW'(NENT-1)) ? '0 : idx_q + 1'b1;
  end

  assign rd_val_o = ent_q[idx_q];
  assign rd_idx_o = idx_q;
endmodule

// File: rtl/memcfg_regs.sv
module memcfg_regs #(
  parameter int unsigned NSOCK = 6,
  parameter int unsigned NENT  = 8,
  parameter int unsigned EW    = 5,
  localparam int unsigned IW   = $clog2(NENT),
  localparam int unsigned DW   = memcfg_pkg::DW,
  localparam int unsigned AW   = memcfg_pkg::AW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [AW-1:0]        addr_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic [2*NSOCK-1:0]   strap_i,
  output logic [DW-1:0]        rdata_o,
  output logic [NENT*EW-1:0]   end_addr_o
);
  import memcfg_pkg::*;

  logic [DW-1:0] id_byte, pres_byte, rd_mux, rdata_q;
  logic [EW-1:0] rd_val;
  logic [IW-1:0] rd_idx;
  logic          rd_end, rd_pres, wr_end;

  assign rd_end  = rd_i && (addr_i == ADDR_END);
  assign rd_pres = rd_i && (addr_i == ADDR_PRES);
  assign wr_end  = wr_i && (addr_i == ADDR_END);

  memcfg_strap_decode #(.NSOCK(NSOCK), .DW(DW)) u_strap (
    .strap_i (strap_i),
    .id_o    (id_byte),
    .pres_o  (pres_byte)
  );

  memcfg_end_table #(.NENT(NENT), .EW(EW)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_end),
    .wr_idx_i   (wdata_i[DW-1 -: IW]),
    .wr_val_i   (wdata_i[EW-1:0]),
    .rd_en_i    (rd_end),
    .clr_idx_i  (rd_pres),
    .rd_val_o   (rd_val),
    .rd_idx_o   (rd_idx),
    .end_addr_o (end_addr_o)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_ID:   rd_mux = id_byte;
      ADDR_PRES: rd_mux = pres_byte;
      ADDR_END:  rd_mux = DW'(rd_val);
      ADDR_PAR:  rd_mux = PAR_OK;
      default:   rd_mux = RD_UNMAP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/memcfg_regs_chk.sv
module memcfg_regs_chk #(
  parameter int unsigned NENT = 8,
  parameter int unsigned EW   = 5,
  parameter int unsigned IW   = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [7:0]          addr_i,
  input logic                rd_i,
  input logic                wr_i,
  input logic [7:0]          rdata_o,
  input logic [NENT*EW-1:0]  end_addr_o,
  input logic [IW-1:0]       rd_idx
);
  assert_idx_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 8'h20) |=> rd_idx == IW'($past(rd_idx) + 1'b1));

  assert_idx_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 8'h04) |=> rd_idx == '0);

  assert_parity_ok_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 8'h41) |=> rdata_o == 8'h01);

  assert_pres_pad_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 8'h04) |=> rdata_o[7:6] == 2'b11);

  assert_ro_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && addr_i != 8'h20) |=> ($stable(end_addr_o) && $stable(rd_idx)));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind memcfg_regs memcfg_regs_chk #(.NENT(NENT), .EW(EW), .IW(IW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .rdata_o    (rdata_o),
  .end_addr_o (end_addr_o),
  .rd_idx     (rd_idx)
);

// File: tb/memcfg_regs_tb.sv
module memcfg_regs_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [11:0] strap_i = '0;
  logic [7:0]  rdata_o;
  logic [39:0] end_addr_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [4:0] tbl [8];
  int idx = 0;
  logic [7:0] exp_d [$];
  string      exp_tag [$];
  logic       rd_seen = 1'b0;

  always #10 clk = ~clk;

  memcfg_regs u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .strap_i(strap_i), .rdata_o(rdata_o), .end_addr_o(end_addr_o)
  );

  task automatic chk(input logic [39:0] act, input logic [39:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [39:0] tbl_flat();
    logic [39:0] v;
    for (int e = 0; e < 8; e++) v[e*5 +: 5] = tbl[e];
    return v;
  endfunction

  function automatic logic [7:0] exp_id();
    logic [7:0] v = 8'h00;
    for (int s = 0; s < 6; s++) if (strap_i[2*s+1]) v[s] = 1'b1;
    return v;
  endfunction

  function automatic logic [7:0] exp_pres();
    logic [7:0] v = 8'hFF;
    for (int s = 0; s < 6; s++) if (strap_i[2*s +: 2] != 2'b00) v[s] = 1'b0;
    return v;
  endfunction

  // driver: one bus cycle, pushes expected read data
  task automatic access(input bit rd, input bit wr, input logic [7:0] a,
                        input logic [7:0] d, input string tag);
    @(negedge clk);
    addr_i = a; rd_i = rd; wr_i = wr; wdata_i = d;
    if (rd) begin
      logic [7:0] e;
      case (a)
        8'h03: e = exp_id();
        8'h04: e = exp_pres();
        8'h20: e = {3'b000, tbl[idx]};
        8'h41: e = 8'h01;
        default: e = 8'hFF;
      endcase
      exp_d.push_back(e);
      exp_tag.push_back(tag);
      if (a == 8'h04) idx = 0;
      else if (a == 8'h20) idx = (idx + 1) % 8;
    end
    if (wr && a == 8'h20) tbl[d[7:5]] = d[4:0];
    @(negedge clk);
    rd_i = 1'b0; wr_i = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= rd_i;

  // monitor: compare registered read data one cycle after the strobe
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_d.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected read data act=%h exp=none", rdata_o);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_d.pop_front();
        t = exp_tag.pop_front();
        chk({32'h0, rdata_o}, {32'h0, e}, t);
      end
    end
  end

  initial begin
    for (int e = 0; e < 8; e++) tbl[e] = '0;
    repeat (3) @(negedge clk);
    chk({32'h0, rdata_o}, 40'h0, "R1 rdata in reset");
    chk(end_addr_o, 40'h0, "R1 table in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk({32'h0, rdata_o}, 40'h0, "R1 rdata after reset");
    access(1, 0, 8'h20, 8'h00, "R1 pointer at 0");

    strap_i = 12'b11_00_01_01_10_10;
    access(1, 0, 8'h03, 8'h00, "R2 large id");
    access(1, 0, 8'h04, 8'h00, "R3 presence");
    strap_i = 12'b00_10_00_01_00_11;
    access(1, 0, 8'h03, 8'h00, "R2 large id alt");
    access(1, 0, 8'h04, 8'h00, "R3 presence alt");
    access(1, 0, 8'h41, 8'h00, "R7 parity");
    access(1, 0, 8'h10, 8'h00, "R8 unmapped read");
    access(1, 0, 8'h42, 8'h00, "R8 unmapped read 2");

    for (int e = 0; e < 8; e++) begin
      access(0, 1, 8'h20, {3'(e), 5'((e * 7 + 3) % 32)}, "R4 write");
      chk(end_addr_o, tbl_flat(), "R4 table after write");
    end
    access(0, 1, 8'h20, {3'd7, 5'h1F}, "R4 write max");
    chk(end_addr_o, tbl_flat(), "R4 max entry");

    access(1, 0, 8'h04, 8'h00, "R6 clear");
    for (int n = 0; n < 10; n++) access(1, 0, 8'h20, 8'h00, "R5 sweep");
    access(1, 0, 8'h04, 8'h00, "R6 clear mid");
    access(1, 0, 8'h20, 8'h00, "R6 restart at 0");

    access(0, 1, 8'h03, 8'hE5, "R8 ro write");
    chk(end_addr_o, tbl_flat(), "R8 ro write ignored");
    access(0, 1, 8'h77, 8'h00, "R8 unmapped write");
    chk(end_addr_o, tbl_flat(), "R8 unmapped write ignored");
    access(1, 0, 8'h20, 8'h00, "R8 pointer kept");

    // pointer now at 2: collide read and write on that entry
    access(1, 1, 8'h20, {3'd2, 5'h15}, "R9 old value");
    chk(end_addr_o, tbl_flat(), "R9 write stored");
    access(1, 0, 8'h20, 8'h00, "R9 pointer advanced");
    access(1, 0, 8'h04, 8'h00, "R9 clear");
    for (int n = 0; n < 3; n++) access(1, 0, 8'h20, 8'h00, "R9 new value");

    begin
      logic [7:0] held;
      held = rdata_o;
      repeat (4) @(negedge clk);
      chk({32'h0, rdata_o}, {32'h0, held}, "R10 hold");
    end

    repeat (2) @(negedge clk);
    if (exp_d.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10 missing reads act=%0d exp=0", exp_d.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule